// File: doc/BRIEF.md
# Load/Store Memory Access Unit

This unit sits between a 32-bit register datapath and a byte-addressed memory built from 32-bit words. On each request it adds a base register value to a 16-bit offset, which is first sign-extended. It checks that the resulting address suits the access size. It then either steers store data onto byte lanes with matching byte enables, or takes the addressed byte or half-word out of a fetched word and widens it to 32 bits.

A static input chooses how byte offsets within a word map onto bit lanes. When it is high, offset 0 is the most significant byte. When it is low, offset 0 is the least significant byte. A misaligned request is not performed. The unit raises a fault flag during that request cycle and suppresses the memory write.

The memory is treated as having an asynchronous read. It returns the word for `mem_addr` in the same cycle as the request. The widened load result is registered and appears one clock later.

Top module: `lsu_top`

## Requirements
- R1: `mem_addr` equals `base_val` plus `offset_imm` sign-extended to 32 bits, taken modulo 2^32. It is combinational from the request inputs.
- R2: `req_size` uses code 0 for byte, 1 for half-word and 2 for word. `fault` is high in the request cycle when `req_valid` is high and either a half-word address has bit 0 set or a word address has a nonzero bits 1:0. A byte access never faults.
- R3: `mem_we` is high only for a valid, non-faulting store. Whenever `mem_we` is low, `mem_be` is 4'b0000.
- R4: For a byte store, `mem_be` has exactly one bit set. With little-endian numbering that bit is `mem_be[ofs]`, and with big-endian numbering it is `mem_be[3-ofs]`, where ofs = `mem_addr[1:0]`. `mem_be[i]` covers `mem_wdata[8i+7:8i]`.
- R5: For a half-word store, `mem_be` is 4'b0011 or 4'b1100. With little-endian numbering, offset 0 selects 4'b0011 and offset 2 selects 4'b1100. Big-endian numbering reverses this.
- R6: For a word store, `mem_be` is 4'b1111.
- R7: `mem_wdata` always carries the low byte of `store_src` in all four lanes for a byte access, and the low half-word in both halves for a half-word access. For a word access it carries `store_src` unchanged.
- R8: A byte load takes the lane chosen as in R4 from `mem_rdata`. When `req_signed` is 1 it is sign-extended, and when `req_signed` is 0 it is zero-extended.
- R9: A half-word load takes the 16-bit lane pair chosen as in R5 from `mem_rdata`. It is sign-extended when `req_signed` is 1 and zero-extended when it is 0.
- R10: A word load returns `mem_rdata` unchanged as the full 32-bit result.
- R11: `load_valid` is high exactly one cycle after a valid, non-faulting load request, and `load_data` is updated then. After a store, a faulting load or an idle cycle, `load_valid` is low and `load_data` holds its value.
- R12: Synchronous reset clears `load_valid` and `load_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Static byte numbering select: 1 means offset 0 is the most significant byte |
| req_valid | input | 1 | Access request present this cycle |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| req_signed | input | 1 | Load extension: 1 sign-extends, 0 zero-extends |
| base_val | input | 32 | Base register value |
| offset_imm | input | 16 | Signed address offset |
| store_src | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word read from `mem_addr` (asynchronous read) |
| mem_addr | output | 32 | Effective byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Lane-replicated store data |
| fault | output | 1 | Misalignment flag for the current request |
| load_valid | output | 1 | Registered load result valid |
| load_data | output | 32 | Registered, extended load result |

## Verification
Two things can happen in the same clock: a load issued in the previous cycle completes on `load_valid`/`load_data`, while the request now on the inputs drives the store lanes, the enables and the fault flag. The stimulus places loads directly before stores and before misaligned requests, in both byte orderings. The behavioural reference model predicts the registered load result and the combinational store and fault outputs independently. Both sets of predictions are compared in every cycle, so a stale or corrupted result in one path cannot hide behind activity in the other.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN   = 32;
    localparam int IMM_W  = 16;
    localparam int LANES  = XLEN / 8;
    localparam int OFS_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic [XLEN-1:0]  ea;
        logic             misaligned;
        logic [OFS_W-1:0] lane;
    } agen_t;

    // Number of bytes moved by an access of the given size (code 3 acts as word).
    function automatic logic [OFS_W:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = (OFS_W+1)'(1);
            SZ_HALF: size_bytes = (OFS_W+1)'(2);
            default: size_bytes = (OFS_W+1)'(LANES);
        endcase
    endfunction

    // Lowest physical lane of the access, after aligning the offset down.
    function automatic logic [OFS_W-1:0] first_lane(input logic [OFS_W-1:0] ofs,
                                                    input logic [1:0]       sz,
                                                    input logic             big);
        logic [OFS_W:0]   nb;
        logic [OFS_W-1:0] al;
        nb = size_bytes(sz);
        al = ofs & ~OFS_W'(nb - 1'b1);
        if (big)
            first_lane = OFS_W'((OFS_W+1)'(LANES) - nb - {1'b0, al});
        else
            first_lane = al;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [XLEN-1:0]   base_val,
    input  logic [IMM_W-1:0]  offset_imm,
    input  logic [1:0]        req_size,
    input  logic              big_endian,
    output agen_t             agen
);
    logic [XLEN-1:0]  ea;
    logic [OFS_W-1:0] ofs;
    logic [OFS_W:0]   nb;

    always_comb begin
        ea  = base_val + {{(XLEN-IMM_W){offset_imm[IMM_W-1]}}, offset_imm};
        ofs = ea[OFS_W-1:0];
        nb  = size_bytes(req_size);
        agen.ea         = ea;
        agen.misaligned = req_valid && ((ofs & OFS_W'(nb - 1'b1)) != '0);
        agen.lane       = first_lane(ofs, req_size, big_endian);
    end

    assert_byte_never_faults_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == SZ_BYTE) |-> !agen.misaligned);

    assert_idle_no_fault_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !agen.misaligned);

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        req_size,
    input  logic [OFS_W-1:0]  lane,
    input  logic [XLEN-1:0]   store_src,
    output logic [LANES-1:0]  be,
    output logic [XLEN-1:0]   wdata
);
    logic [LANES-1:0] mask;

    always_comb begin
        case (req_size)
            SZ_BYTE: mask = LANES'(1);
            SZ_HALF: mask = LANES'(3);
            default: mask = '1;
        endcase
        be = wr_en ? (mask << lane) : '0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (req_size)
                SZ_BYTE: wdata[8*i +: 8] = store_src[7:0];
                SZ_HALF: wdata[8*i +: 8] = store_src[8*(i%2) +: 8];
                default: wdata[8*i +: 8] = store_src[8*i +: 8];
            endcase
        end
    end

    assert_byte_store_one_lane_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req_size == SZ_BYTE) |-> ($countones(be) == 1));

    assert_half_store_pair_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req_size == SZ_HALF) |-> (be == 4'b0011 || be == 4'b1100));

    assert_word_store_all_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req_size == SZ_WORD) |-> (be == 4'b1111));

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [OFS_W-1:0]  lane,
    input  logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   result
);
    logic [XLEN-1:0] shifted;
    logic [7:0]      b;
    logic [15:0]     h;

    always_comb begin
        shifted = rdata >> {lane, 3'b000};
        b = shifted[7:0];
        h = shifted[15:0];
        case (req_size)
            SZ_BYTE: result = {{(XLEN-8){req_signed & b[7]}}, b};
            SZ_HALF: result = {{(XLEN-16){req_signed & h[15]}}, h};
            default: result = rdata;
        endcase
    end

endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         big_endian,
    input  logic         req_valid,
    input  logic         req_store,
    input  logic [1:0]   req_size,
    input  logic         req_signed,
    input  logic [31:0]  base_val,
    input  logic [15:0]  offset_imm,
    input  logic [31:0]  store_src,
    input  logic [31:0]  mem_rdata,
    output logic [31:0]  mem_addr,
    output logic         mem_we,
    output logic [3:0]   mem_be,
    output logic [31:0]  mem_wdata,
    output logic         fault,
    output logic         load_valid,
    output logic [31:0]  load_data
);
    agen_t           agen;
    logic            wr_en;
    logic            ld_go;
    logic [XLEN-1:0] ld_result;

    lsu_agen u_agen (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .base_val   (base_val),
        .offset_imm (offset_imm),
        .req_size   (req_size),
        .big_endian (big_endian),
        .agen       (agen)
    );

    assign fault    = agen.misaligned;
    assign mem_addr = agen.ea;
    assign wr_en    = req_valid && req_store && !agen.misaligned;
    assign ld_go    = req_valid && !req_store && !agen.misaligned;
    assign mem_we   = wr_en;

    lsu_store_steer u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .req_size  (req_size),
        .lane      (agen.lane),
        .store_src (store_src),
        .be        (mem_be),
        .wdata     (mem_wdata)
    );

    lsu_load_extract u_load (
        .req_size   (req_size),
        .req_signed (req_signed),
        .lane       (agen.lane),
        .rdata      (mem_rdata),
        .result     (ld_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            load_valid <= 1'b0;
            load_data  <= '0;
        end else begin
            load_valid <= ld_go;
            if (ld_go)
                load_data <= ld_result;
        end
    end

    assert_fault_blocks_write_R3: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!mem_we && mem_be == 4'b0000));

    assert_no_enable_without_we_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> (mem_be == 4'b0000));

    assert_load_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_store && !fault) |=> load_valid);

    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_store && !fault) |=> (!load_valid && $stable(load_data)));

    assert_reset_clears_R12: assert property (@(posedge clk)
        rst |=> (!load_valid && load_data == 32'd0));

endmodule

// File: tb/lsu_top_bench.sv
module lsu_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        big_endian;
    logic        req_valid, req_store, req_signed;
    logic [1:0]  req_size;
    logic [31:0] base_val, store_src, mem_rdata;
    logic [15:0] offset_imm;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic        mem_we, fault, load_valid;
    logic [3:0]  mem_be;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    logic        exp_lv;
    logic [31:0] exp_ld;
    int          exp_tag;

    always #4 clk = ~clk;

    lsu_top u_lsu_top (
        .clk(clk), .rst(rst), .big_endian(big_endian),
        .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
        .req_signed(req_signed), .base_val(base_val), .offset_imm(offset_imm),
        .store_src(store_src), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata), .fault(fault),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string ld_tag(input int sz);
        if (sz == 0) return "R8";
        if (sz == 1) return "R9";
        return "R10";
    endfunction

    function automatic string st_tag(input int sz);
        if (sz == 0) return "R4";
        if (sz == 1) return "R5";
        return "R6";
    endfunction

    // One request cycle: check registered outputs, drive, check combinational
    // outputs against the reference model, and predict the next load result.
    task automatic step(input bit v, input bit st, input int sz, input bit sg,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] src, input logic [31:0] rd);
        logic [31:0] ea, wd, res;
        logic [3:0]  be;
        logic        flt;
        int          o, sh;
        @(negedge clk);
        chk("R11 load_valid", {31'd0, load_valid}, {31'd0, exp_lv});
        chk(exp_lv ? ld_tag(exp_tag) : "R11 hold", load_data, exp_ld);
        req_valid = v; req_store = st; req_size = 2'(sz); req_signed = sg;
        base_val = base; offset_imm = off; store_src = src; mem_rdata = rd;
        #1;
        ea  = base + {{16{off[15]}}, off};
        o   = int'(ea[1:0]);
        flt = v && ((sz == 1 && ea[0]) || (sz == 2 && ea[1:0] != 2'b00));
        if (sz == 0)      sh = big_endian ? (3 - o) * 8 : o * 8;
        else if (sz == 1) sh = big_endian ? (2 - (o & 2)) * 8 : (o & 2) * 8;
        else              sh = 0;
        if (sz == 0)      begin be = 4'b0001 << (sh / 8); wd = {4{src[7:0]}}; end
        else if (sz == 1) begin be = 4'b0011 << (sh / 8); wd = {2{src[15:0]}}; end
        else              begin be = 4'b1111;             wd = src;            end
        if (!(v && st && !flt)) be = 4'b0000;
        if (sz == 0)      res = sg ? 32'(signed'(8'(rd >> sh)))  : 32'(8'(rd >> sh));
        else if (sz == 1) res = sg ? 32'(signed'(16'(rd >> sh))) : 32'(16'(rd >> sh));
        else              res = rd;
        chk("R1 mem_addr", mem_addr, ea);
        chk("R2 fault", {31'd0, fault}, {31'd0, flt});
        chk("R3 mem_we", {31'd0, mem_we}, {31'd0, v && st && !flt});
        chk((v && st && !flt) ? st_tag(sz) : "R3 be", {28'd0, mem_be}, {28'd0, be});
        chk("R7 mem_wdata", mem_wdata, wd);
        exp_lv = v && !st && !flt;
        if (exp_lv) begin exp_ld = res; exp_tag = sz; end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fails++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; big_endian = 1'b0;
        req_valid = 0; req_store = 0; req_size = 0; req_signed = 0;
        base_val = 0; offset_imm = 0; store_src = 0; mem_rdata = 0;
        exp_lv = 0; exp_ld = 0; exp_tag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset valid", {31'd0, load_valid}, 32'd0);
        chk("R12 reset data", load_data, 32'd0);
        rst = 1'b0;
        for (int e = 0; e < 2; e++) begin
            big_endian = e[0];
            for (int sz = 0; sz < 3; sz++)
                for (int o = 0; o < 4; o++)
                    for (int sg = 0; sg < 2; sg++) begin
                        // load, then a store right behind it
                        step(1, 0, sz, sg[0], 32'h1000_0010 + o, 16'hFFF8,
                             32'h0, 32'h80F1_7F02 ^ (o * 32'h0101_0101));
                        step(1, 1, sz, 0, 32'h2000_0000 + o, 16'h0004,
                             32'hA5C3_96E1 + o, 32'hDEAD_BEEF);
                    end
        end
        // wrap-around address, idle cycle, misaligned load holding old data
        big_endian = 1'b0;
        step(1, 0, 2, 0, 32'hFFFF_FFFC, 16'h0004, 32'h0, 32'h1234_5678);
        step(0, 0, 2, 0, 32'h0, 16'h0, 32'h0, 32'h0);
        step(1, 0, 1, 1, 32'h0000_0001, 16'h0000, 32'h0, 32'hFFFF_FFFF);
        step(1, 1, 2, 0, 32'h0000_0002, 16'h0000, 32'hFFFF_FFFF, 32'h0);
        for (int i = 0; i < 300; i++) begin
            big_endian = (i / 150) == 1;
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                 int'($urandom_range(0, 2)), $urandom_range(0, 1) == 1,
                 $urandom, 16'($urandom), $urandom, $urandom);
        end
        step(0, 0, 0, 0, 32'h0, 16'h0, 32'h0, 32'h0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule